// File: doc/BRIEF.md
# DMA Channel Event Trigger Controller

This block decides, for one DMA channel, when a transfer begins and when it is cut short. Software programs a 32-bit event control word over a plain write/read port. The word holds two 8-bit interrupt selectors, one for start and one for abort, and three enables: start-on-interrupt, abort-on-interrupt and abort-on-pattern-match. It also holds two write-one strobes, force-start and force-abort.

Each cycle the block compares the incoming interrupt number, which is qualified by a one-cycle valid strobe, against both selectors. It also watches a pattern-match strobe from the data path and the channel's enable and busy state. From these it issues registered one-cycle pulses: start, abort, channel-enable clear, and abort-flag set.

The data mover, the pattern comparator and the interrupt controller lie outside the block. They are reached only through these ports.

Top module: `dma_evt_trigger`

## Requirements
- R1: After reset the control word reads 0x00FFFF00. Both selectors read 255 and every enable reads 0.
- R2: Readback layout: bits 23:16 hold the abort selector, bits 15:8 the start selector, bit 5 the pattern-abort enable, bit 4 the start-IRQ enable and bit 3 the abort-IRQ enable. Bits 31:24, 7:6 and 2:0 always read 0, including right after a write of 1 to bit 7 or bit 6.
- R3: A valid interrupt whose number equals the start selector starts a transfer, provided bit 4 is set and the channel is enabled.
- R4: A bus write with bit 7 set starts a transfer when the channel is enabled.
- R5: A valid interrupt whose number equals the abort selector aborts the transfer when bit 3 is set and the channel is busy. It also sets the abort flag.
- R6: A bus write with bit 6 set aborts the transfer when the channel is busy. This abort does not set the abort flag.
- R7: A pattern-match strobe while bit 5 is set and the channel is busy aborts the transfer and also issues a channel-enable clear.
- R8: When bit 4, bit 3 or bit 5 is clear, the event that bit enables has no effect. Matching interrupt numbers, interrupts with no valid strobe, and pattern matches give no pulse.
- R9: Start requests are ignored while the channel enable is low. Abort requests are ignored while the channel is not busy.
- R10: When a start request and an abort request occur in the same cycle, only the abort pulse is issued.
- R11: Every output pulse lasts one cycle and appears in the cycle after its triggering event or bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word readback |
| irq_valid | input | 1 | Interrupt event valid, one cycle |
| irq_num | input | 8 | Interrupt event number |
| pat_match | input | 1 | Pattern-match strobe from the data path |
| chan_en | input | 1 | Channel enable state |
| chan_busy | input | 1 | Channel transfer in progress |
| start_pulse | output | 1 | Start transfer pulse |
| abort_pulse | output | 1 | Abort transfer pulse |
| en_clr_pulse | output | 1 | Request to clear the channel enable |
| abort_flag_set | output | 1 | Set the channel abort-interrupt flag |

## Verification
The vector table drives interrupt numbers that match the start selector, match the abort selector, match neither, or arrive without their valid strobe. Each pattern is repeated with the enable and busy inputs toggled, so it separates a selector compare error from a gating error. Force, abort and pattern-match events are applied alone and in colliding pairs, to show the abort-priority rule and to show which abort sources raise the flag or the enable clear. Directed cases read the control word after reset and after writes that set the strobe and unused bits, and they check the reset selector of 255 and the cleared enables.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 8;
  localparam int ASEL_LO = 16;
  localparam int SSEL_LO = 8;
  localparam int FRC_BIT = 7;
  localparam int ABT_BIT = 6;
  localparam int PEN_BIT = 5;
  localparam int SEN_BIT = 4;
  localparam int AEN_BIT = 3;

  typedef struct packed {
    logic [SEL_W-1:0] abort_sel;
    logic [SEL_W-1:0] start_sel;
    logic             pat_en;
    logic             start_en;
    logic             abort_en;
  } evt_cfg_t;

  localparam evt_cfg_t CFG_RESET = '{abort_sel: '1, start_sel: '1,
                                     pat_en: 1'b0, start_en: 1'b0, abort_en: 1'b0};

  function automatic logic [WORD_W-1:0] pack_word(evt_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ASEL_LO +: SEL_W] = c.abort_sel;
    w[SSEL_LO +: SEL_W] = c.start_sel;
    w[PEN_BIT] = c.pat_en;
    w[SEN_BIT] = c.start_en;
    w[AEN_BIT] = c.abort_en;
    return w;
  endfunction

  function automatic evt_cfg_t unpack_word(logic [WORD_W-1:0] w);
    evt_cfg_t c;
    c.abort_sel = w[ASEL_LO +: SEL_W];
    c.start_sel = w[SSEL_LO +: SEL_W];
    c.pat_en    = w[PEN_BIT];
    c.start_en  = w[SEN_BIT];
    c.abort_en  = w[AEN_BIT];
    return c;
  endfunction

  function automatic logic sel_hit(logic vld, logic en, logic [SEL_W-1:0] num,
                                   logic [SEL_W-1:0] sel);
    return vld & en & (num == sel);
  endfunction
endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import dma_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output evt_cfg_t          cfg,
  output logic [WORD_W-1:0] rdata,
  output logic              force_stb,
  output logic              abort_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= CFG_RESET;
    else if (wr) cfg <= unpack_word(wdata);
  end

  assign rdata     = pack_word(cfg);
  assign force_stb = wr & wdata[FRC_BIT];
  assign abort_stb = wr & wdata[ABT_BIT];
endmodule

// File: rtl/evt_irq_match.sv
module evt_irq_match #(
  parameter int SEL_W = 8
) (
  input  logic             vld,
  input  logic             en,
  input  logic [SEL_W-1:0] num,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  assign hit = vld & en & (num == sel);
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic abort_req,
  input  logic clr_req,
  input  logic flag_req,
  output logic start_pulse,
  output logic abort_pulse,
  output logic en_clr_pulse,
  output logic abort_flag_set
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse    <= 1'b0;
      abort_pulse    <= 1'b0;
      en_clr_pulse   <= 1'b0;
      abort_flag_set <= 1'b0;
    end else begin
      start_pulse    <= start_req;
      abort_pulse    <= abort_req;
      en_clr_pulse   <= clr_req;
      abort_flag_set <= flag_req;
    end
  end
endmodule

// File: rtl/dma_evt_trigger.sv
module dma_evt_trigger
  import dma_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              irq_valid,
  input  logic [SEL_W-1:0]  irq_num,
  input  logic              pat_match,
  input  logic              chan_en,
  input  logic              chan_busy,
  output logic              start_pulse,
  output logic              abort_pulse,
  output logic              en_clr_pulse,
  output logic              abort_flag_set
);
  localparam int NSEL = 2;

  evt_cfg_t cfg;
  logic force_stb, abort_stb;
  logic start_hit, abort_hit, pat_hit;
  logic start_req, abort_req, clr_req, flag_req;
  logic [SEL_W-1:0] sel_vec [NSEL];
  logic             en_vec  [NSEL];
  logic             hit_vec [NSEL];

  evt_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .cfg(cfg), .rdata(bus_rdata), .force_stb(force_stb), .abort_stb(abort_stb)
  );

  assign sel_vec[0] = cfg.start_sel;
  assign en_vec[0]  = cfg.start_en;
  assign sel_vec[1] = cfg.abort_sel;
  assign en_vec[1]  = cfg.abort_en;

  for (genvar i = 0; i < NSEL; i++) begin : g_match
    evt_irq_match #(.SEL_W(SEL_W)) u_match (
      .vld(irq_valid), .en(en_vec[i]), .num(irq_num),
      .sel(sel_vec[i]), .hit(hit_vec[i])
    );
  end

  assign start_hit = hit_vec[0];
  assign abort_hit = hit_vec[1];
  assign pat_hit   = cfg.pat_en & pat_match;

  assign abort_req = chan_busy & (abort_hit | abort_stb | pat_hit);
  assign start_req = chan_en & (start_hit | force_stb) & ~abort_req;
  assign clr_req   = chan_busy & pat_hit;
  assign flag_req  = chan_busy & abort_hit;

  evt_pulse_gen u_pulse (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .abort_req(abort_req),
    .clr_req(clr_req), .flag_req(flag_req),
    .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .en_clr_pulse(en_clr_pulse), .abort_flag_set(abort_flag_set)
  );
endmodule

// File: rtl/dma_evt_trigger_checker.sv
module dma_evt_trigger_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_rdata,
  input logic        chan_en,
  input logic        chan_busy,
  input logic        start_req,
  input logic        abort_req,
  input logic        start_pulse,
  input logic        abort_pulse,
  input logic        en_clr_pulse,
  input logic        abort_flag_set
);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 32'hFF0000C7) == 32'h0);
  a_r10_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && abort_pulse));
  a_r11_start_timing: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> start_pulse);
  a_r11_abort_timing: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> abort_pulse);
  a_r9_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> chan_en);
  a_r9_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> chan_busy);
  a_r7_clr_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_pulse |-> abort_pulse);
  a_r5_flag_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag_set |-> abort_pulse);
endmodule

bind dma_evt_trigger dma_evt_trigger_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata),
  .chan_en(chan_en), .chan_busy(chan_busy),
  .start_req(start_req), .abort_req(abort_req),
  .start_pulse(start_pulse), .abort_pulse(abort_pulse),
  .en_clr_pulse(en_clr_pulse), .abort_flag_set(abort_flag_set)
);

// File: tb/dma_evt_trigger_test.sv
module dma_evt_trigger_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_valid = 1'b0;
  logic [7:0] irq_num = '0;
  logic pat_match = 1'b0, chan_en = 1'b0, chan_busy = 1'b0;
  logic start_pulse, abort_pulse, en_clr_pulse, abort_flag_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_evt_trigger uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_num(irq_num),
    .pat_match(pat_match), .chan_en(chan_en), .chan_busy(chan_busy),
    .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .en_clr_pulse(en_clr_pulse), .abort_flag_set(abort_flag_set)
  );

  // abort selector 0x21, start selector 0x12, all three enables (bits 5:3) set
  localparam logic [31:0] CFG = 32'h0021_1238;

  // {irq_valid, irq_num[7:0], pat, en, busy, force, abort, exp{start,abort,clr,flag}}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000}, // R3 start match
    {1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 en low
    {1'b1, 8'h21, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0101}, // R5 abort + flag
    {1'b1, 8'h21, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 not busy
    {1'b1, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000}, // R3 no match
    {1'b0, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R8 no valid
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0110}, // R7 pattern
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 pattern idle
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1000}, // R4 force
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000}, // R9 force en low
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0100}, // R6 sw abort
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R9 sw abort idle
    {1'b1, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0110}, // R10 irq start vs pattern
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0100}, // R10 force vs abort
    {1'b1, 8'h21, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0101}  // R10 force vs irq abort
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic outs_of(output logic [3:0] o);
    o = {start_pulse, abort_pulse, en_clr_pulse, abort_flag_set};
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", bus_rdata, 32'h00FF_FF00);
    outs_of(o);
    chk("R1 reset outputs", {28'h0, o}, 32'h0);

    wr(CFG | 32'hFF00_00C7);
    chk("R2 readback strips unused/strobe bits", bus_rdata, CFG);
    wr(CFG);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      @(negedge clk);
      irq_valid = v[17]; irq_num = v[16:9]; pat_match = v[8];
      chan_en = v[7]; chan_busy = v[6];
      bus_wr = v[5] | v[4];
      bus_wdata = CFG | (32'(v[5]) << 7) | (32'(v[4]) << 6);
      @(negedge clk);
      outs_of(o);
      chk($sformatf("R11 vector %0d", i), {28'h0, o}, {28'h0, v[3:0]});
      irq_valid = 1'b0; pat_match = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      @(negedge clk);
      outs_of(o);
      chk($sformatf("R11 vector %0d pulse ends", i), {28'h0, o}, 32'h0);
    end
    chk("R2 strobes read zero after use", bus_rdata, CFG);

    // R8: enables cleared, selectors kept
    wr(32'h0021_1200);
    @(negedge clk);
    chan_en = 1'b1; chan_busy = 1'b1;
    irq_valid = 1'b1; irq_num = 8'h12;
    @(negedge clk);
    outs_of(o);
    chk("R8 start irq disabled", {28'h0, o}, 32'h0);
    irq_num = 8'h21;
    @(negedge clk);
    outs_of(o);
    chk("R8 abort irq disabled", {28'h0, o}, 32'h0);
    irq_valid = 1'b0; pat_match = 1'b1;
    @(negedge clk);
    outs_of(o);
    chk("R8 pattern disabled", {28'h0, o}, 32'h0);
    pat_match = 1'b0;

    // R3: reset selector value 255 with start enable only
    chan_busy = 1'b0;
    wr(32'h00FF_FF10);
    chk("R2 readback start-enable word", bus_rdata, 32'h00FF_FF10);
    @(negedge clk);
    irq_valid = 1'b1; irq_num = 8'hFF;
    @(negedge clk);
    outs_of(o);
    chk("R3 selector 255 start", {28'h0, o}, 32'h8);
    irq_valid = 1'b0;
    @(negedge clk);

    // R1: reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after second reset", bus_rdata, 32'h00FF_FF00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule